// File: doc/BRIEF.md
# Channel Fault Restart Sequencer

This block decides, for every audio output channel, what happens after the channel's short-circuit protection trips. Each channel has its own state machine, so a fault on one channel shuts down that channel alone while the others keep running. Time is measured in ticks of a 1 ms strobe supplied from outside; the block measures no current itself. It reads an overload flag and three fault-type flags per channel, which come from analog comparators.

With diagnostics off, or with no diagnostic cycle armed, a tripped channel is in restart mode. It stays off and tests the overload flag on every tick. It comes back on at the first tick that finds the overload gone. With diagnostics on and a cycle armed, the first tick after the trip is a debounce check. If the overload has already gone, the channel simply resumes. If the overload is still present, a diagnostic cycle of `DIAG_TICKS` ticks runs (100 by default). The fault type is captured when the cycle starts. The fault code is stored at the end of the cycle only if the fault type and the overload held steady on every clock of the cycle. The channel then falls back to restart mode. A further cycle on that channel is armed only when the host pulses the read strobe.

States, per channel: `ST_RUN` (channel enabled), `ST_RESTART` (off, polled each tick), `ST_DEBOUNCE` (off, waiting for the 1 ms check), `ST_DIAG` (off, diagnostic cycle running). The transitions are:
- RUN→DEBOUNCE on overload when diagnostics are on and a cycle is armed.
- RUN→RESTART on overload otherwise.
- RESTART→RUN on a tick with the overload clear.
- DEBOUNCE→RUN on a tick with the overload clear.
- DEBOUNCE→DIAG on a tick with the overload present.
- DEBOUNCE→RESTART when diagnostics are turned off.
- DIAG→RESTART on the last tick of the cycle, which stores the code.
- DIAG→RESTART when diagnostics are turned off, which aborts the cycle without storing anything.

Top module: `chan_fault_seq`

## Requirements
- R1: After reset, every channel is enabled, every stored fault code is 000 and every channel has a diagnostic cycle armed.
- R2: An overload on an enabled channel drops that channel's enable on the next clock. The enables of the other channels do not change.
- R3: In restart mode a channel stays disabled until a clock on which the tick is high and the overload is low. Its enable rises after that clock.
- R4: In diagnostic mode, if the overload is gone at the first tick after the trip, the channel is re-enabled after that tick, no cycle runs and the stored code is unchanged.
- R5: If the overload is still present at the first tick, a cycle starts. The code is stored on the clock of the DIAG_TICKS-th tick after the start, and not earlier. The channel stays disabled and is in restart mode afterwards.
- R6: The code is one-hot: bit 0 means short to ground, bit 1 short to supply, bit 2 short across the load. When several flags are set, ground wins over supply and supply wins over load. With no flag set the code is 000.
- R7: If the fault type or the overload changes on any clock of the cycle, the code stored at its end is 000.
- R8: After a completed cycle, a later overload on that channel is handled in restart mode with no new cycle, and the stored code keeps its value, until the read strobe is pulsed.
- R9: The read strobe arms the next cycle on every channel. It does not clear the stored codes, which remain until a later completed cycle replaces them.
- R10: Turning diagnostics off during a cycle aborts it. The channel goes to restart mode and the stored code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-clock strobe every 1 ms |
| diag_en | input | 1 | Diagnostic mode enable |
| rd_strobe | input | 1 | Host read strobe; arms the next cycle |
| ovl | input | NUM_CH | Overload flag per channel |
| flt_gnd | input | NUM_CH | Short-to-ground flag per channel |
| flt_sup | input | NUM_CH | Short-to-supply flag per channel |
| flt_load | input | NUM_CH | Short-across-load flag per channel |
| ch_en | output | NUM_CH | Channel enable |
| fault_code | output | 3*NUM_CH | Stored one-hot fault code, channel c at bits [3c+2:3c] |

## Verification
The bench sweeps all eight combinations of the fault flags through complete cycles and compares the stored code with the priority encoding. An encoder with the wrong priority or a swapped bit would fail this sweep. It counts ticks right up to the edge of the cycle: a counter that is one tick off would show the code a tick early or late. It glitches a fault flag in the middle of a cycle, which catches a design that keeps its first sample instead of requiring stability. It skips the read strobe between overloads and drops diagnostics mid-cycle; ignoring the arming gate or latching on abort would change a code that must stay fixed. It also watches a second channel throughout, so state shared between channels would show up as a disabled neighbour.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_RESTART,
        ST_DEBOUNCE,
        ST_DIAG
    } chan_state_t;

    localparam int CODE_W = 3;
    typedef logic [CODE_W-1:0] fault_code_t;

    localparam fault_code_t CODE_NONE = 3'b000;
    localparam fault_code_t CODE_GND  = 3'b001;
    localparam fault_code_t CODE_SUP  = 3'b010;
    localparam fault_code_t CODE_LOAD = 3'b100;
endpackage

// File: rtl/fault_prio_enc.sv
module fault_prio_enc
    import cfs_pkg::*;
(
    input  logic        is_gnd,
    input  logic        is_sup,
    input  logic        is_load,
    output fault_code_t code
);
    // Ground outranks supply, supply outranks load.
    always_comb begin
        if (is_gnd)       code = CODE_GND;
        else if (is_sup)  code = CODE_SUP;
        else if (is_load) code = CODE_LOAD;
        else              code = CODE_NONE;
    end
endmodule

// File: rtl/chan_fault_fsm.sv
module chan_fault_fsm
    import cfs_pkg::*;
#(
    parameter int DIAG_TICKS = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1ms,
    input  logic        diag_en,
    input  logic        rd_strobe,
    input  logic        ovl,
    input  fault_code_t flt_code,
    output logic        ch_en,
    output fault_code_t code_q
);
    localparam int CNT_W = $clog2(DIAG_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIAG_TICKS - 1);

    chan_state_t      state, nxt;
    logic [CNT_W-1:0] tick_cnt;
    fault_code_t      snap;
    logic             steady;
    logic             armed;
    logic             last_tick;
    logic             enter_diag;
    logic             cycle_done;
    logic             still_same;

    assign last_tick  = (tick_cnt == LAST_CNT);
    assign still_same = ovl && (flt_code == snap);
    assign enter_diag = (state == ST_DEBOUNCE) && diag_en && tick_1ms && ovl;
    assign cycle_done = (state == ST_DIAG) && diag_en && tick_1ms && last_tick;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (ovl) nxt = (diag_en && armed) ? ST_DEBOUNCE : ST_RESTART;
            end
            ST_RESTART: begin
                if (tick_1ms && !ovl) nxt = ST_RUN;
            end
            ST_DEBOUNCE: begin
                if (!diag_en)      nxt = ST_RESTART;
                else if (tick_1ms) nxt = ovl ? ST_DIAG : ST_RUN;
            end
            ST_DIAG: begin
                if (!diag_en)        nxt = ST_RESTART;
                else if (cycle_done) nxt = ST_RESTART;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        ch_en = (state == ST_RUN);
    end

    // Cycle datapath: tick counter, snapshot, stability, result, arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            snap     <= CODE_NONE;
            steady   <= 1'b0;
            code_q   <= CODE_NONE;
            armed    <= 1'b1;
        end else begin
            if (enter_diag) begin
                tick_cnt <= '0;
                snap     <= flt_code;
                steady   <= 1'b1;
            end else if (state == ST_DIAG) begin
                if (tick_1ms)    tick_cnt <= tick_cnt + CNT_W'(1);
                if (!still_same) steady   <= 1'b0;
            end
            if (cycle_done)
                code_q <= (steady && still_same) ? snap : CODE_NONE;
            if (rd_strobe)       armed <= 1'b1;
            else if (cycle_done) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_fault_seq.sv
module chan_fault_seq
    import cfs_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int DIAG_TICKS = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_1ms,
    input  logic                     diag_en,
    input  logic                     rd_strobe,
    input  logic [NUM_CH-1:0]        ovl,
    input  logic [NUM_CH-1:0]        flt_gnd,
    input  logic [NUM_CH-1:0]        flt_sup,
    input  logic [NUM_CH-1:0]        flt_load,
    output logic [NUM_CH-1:0]        ch_en,
    output logic [NUM_CH*CODE_W-1:0] fault_code
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fault_code_t enc_code;
        fault_code_t held_code;

        fault_prio_enc u_enc (
            .is_gnd  (flt_gnd[c]),
            .is_sup  (flt_sup[c]),
            .is_load (flt_load[c]),
            .code    (enc_code)
        );

        chan_fault_fsm #(.DIAG_TICKS(DIAG_TICKS)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_1ms  (tick_1ms),
            .diag_en   (diag_en),
            .rd_strobe (rd_strobe),
            .ovl       (ovl[c]),
            .flt_code  (enc_code),
            .ch_en     (ch_en[c]),
            .code_q    (held_code)
        );

        assign fault_code[c*CODE_W +: CODE_W] = held_code;
    end
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker
    import cfs_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick_1ms,
    input logic [NUM_CH-1:0]        ovl,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH*CODE_W-1:0] fault_code
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2
        ovl_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[c] && ovl[c]) |=> !ch_en[c]);

        // R3
        reenable_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_en[c]) |-> ($past(tick_1ms) && !$past(ovl[c])));

        // R6
        code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(fault_code[c*CODE_W +: CODE_W]));

        // R5
        code_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(fault_code[c*CODE_W +: CODE_W]) |-> $past(tick_1ms));

        // R5
        code_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(fault_code[c*CODE_W +: CODE_W]) |-> !ch_en[c]);
    end
endmodule

bind chan_fault_seq cfs_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1ms   (tick_1ms),
    .ovl        (ovl),
    .ch_en      (ch_en),
    .fault_code (fault_code)
);

// File: tb/chan_fault_seq_test.sv
module chan_fault_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int DT         = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_1ms = 1'b0;
    logic           diag_en = 1'b0;
    logic           rd_strobe = 1'b0;
    logic [NCH-1:0] ovl = '0;
    logic [NCH-1:0] flt_gnd = '0;
    logic [NCH-1:0] flt_sup = '0;
    logic [NCH-1:0] flt_load = '0;
    logic [NCH-1:0] ch_en;
    logic [NCH*3-1:0] fault_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_fault_seq #(.NUM_CH(NCH), .DIAG_TICKS(DT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .diag_en(diag_en),
        .rd_strobe(rd_strobe), .ovl(ovl), .flt_gnd(flt_gnd), .flt_sup(flt_sup),
        .flt_load(flt_load), .ch_en(ch_en), .fault_code(fault_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    function automatic int code_of(input int c);
        return int'(fault_code[c*3 +: 3]);
    endfunction

    function automatic int prio(input int v);
        if (v % 2 == 1)      return 1;
        if ((v / 2) % 2 == 1) return 2;
        if ((v / 4) % 2 == 1) return 4;
        return 0;
    endfunction

    task automatic set_flags(input int c, input int v);
        flt_gnd[c]  = (v % 2) == 1;
        flt_sup[c]  = ((v / 2) % 2) == 1;
        flt_load[c] = ((v / 4) % 2) == 1;
    endtask

    // trip, debounce tick, DT cycle ticks, then clear and restart
    task automatic full_cycle(input int c, input int v);
        set_flags(c, v);
        ovl[c] = 1'b1;
        @(negedge clk);
        do_tick();
        for (int k = 0; k < DT; k++) do_tick();
        ovl[c] = 1'b0;
        do_tick();
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            report();
        end
    end

    initial begin
        int prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ch_en", int'(ch_en), 3);
        check("R1 code", int'(fault_code), 0);

        // R2/R3 restart mode with diagnostics off
        ovl[0] = 1'b1;
        @(negedge clk);
        check("R2 faulted ch off", int'(ch_en[0]), 0);
        check("R2 other ch on", int'(ch_en[1]), 1);
        do_tick();
        check("R3 still faulted at tick", int'(ch_en[0]), 0);
        ovl[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R3 no tick no restart", int'(ch_en[0]), 0);
        do_tick();
        check("R3 restart on tick", int'(ch_en[0]), 1);

        // R5/R6/R9 sweep over all flag combinations on channel 0
        diag_en = 1'b1;
        prev = 0;
        for (int v = 0; v < 8; v++) begin
            set_flags(0, v);
            ovl[0] = 1'b1;
            @(negedge clk);
            do_tick();
            for (int k = 0; k < DT - 1; k++) do_tick();
            check("R5 code not early", code_of(0), prev);
            check("R5 off during cycle", int'(ch_en[0]), 0);
            check("R2 neighbour on", int'(ch_en[1]), 1);
            do_tick();
            check("R6 code", code_of(0), prio(v));
            check("R5 off after cycle", int'(ch_en[0]), 0);
            ovl[0] = 1'b0;
            do_tick();
            check("R5 restart after cycle", int'(ch_en[0]), 1);
            do_read();
            check("R9 read keeps code", code_of(0), prio(v));
            prev = prio(v);
        end

        // R4 debounce: overload gone by first tick
        set_flags(0, 2);
        ovl[0] = 1'b1;
        @(negedge clk);
        ovl[0] = 1'b0;
        do_tick();
        check("R4 resumes", int'(ch_en[0]), 1);
        for (int k = 0; k < DT + 1; k++) do_tick();
        check("R4 code unchanged", code_of(0), prev);

        // R7 instability on channel 1: first a good cycle, then a glitched one
        full_cycle(1, 2);
        check("R6 ch1 supply", code_of(1), 2);
        do_read();
        set_flags(1, 1);
        ovl[1] = 1'b1;
        @(negedge clk);
        do_tick();
        do_tick();
        flt_gnd[1] = 1'b0;
        @(negedge clk);
        flt_gnd[1] = 1'b1;
        @(negedge clk);
        for (int k = 0; k < DT - 1; k++) do_tick();
        check("R7 unstable gives none", code_of(1), 0);
        check("R7 ch0 code untouched", code_of(0), prev);
        ovl[1] = 1'b0;
        do_tick();
        do_read();

        // R8 no read: second overload handled as restart only
        full_cycle(0, 4);
        check("R8 load code", code_of(0), 4);
        set_flags(0, 1);
        ovl[0] = 1'b1;
        @(negedge clk);
        check("R8 off", int'(ch_en[0]), 0);
        for (int k = 0; k < DT + 2; k++) do_tick();
        check("R8 code kept", code_of(0), 4);
        ovl[0] = 1'b0;
        do_tick();
        check("R8 restart path", int'(ch_en[0]), 1);

        // R9 read arms a new cycle
        do_read();
        full_cycle(0, 1);
        check("R9 new cycle stored", code_of(0), 1);
        do_read();

        // R10 abort by dropping diagnostics
        set_flags(0, 2);
        ovl[0] = 1'b1;
        @(negedge clk);
        do_tick();
        do_tick();
        diag_en = 1'b0;
        @(negedge clk);
        diag_en = 1'b1;
        for (int k = 0; k < DT + 1; k++) do_tick();
        check("R10 code unchanged", code_of(0), 1);
        check("R10 still off", int'(ch_en[0]), 0);
        ovl[0] = 1'b0;
        do_tick();
        check("R10 restart", int'(ch_en[0]), 1);

        done = 1'b1;
        report();
    end
endmodule